// File: doc/BRIEF.md
# Edge Port Interrupt Unit

This block takes up to eight external pin inputs and turns them into interrupt request lines for a downstream interrupt controller. Pin positions 1 to 7 can act as interrupt sources. Position 0 is reserved and never raises a request. Every pin is resynchronized by a two-flop chain. After that, the pin is compared with its value one cycle earlier so that rising and falling edges can be detected. A per-pin trigger field selects one of four modes: active-low level, rising edge, falling edge or either edge.

Edge events latch into a per-pin flag. Software acknowledges a flag by writing a 1 to its bit. In level mode the flag simply mirrors the synchronized pin while the pin is held low. A pin contributes a request only when it is configured as an input and its enable bit is set. A small register bus gives access to the configuration, the data-out value, the synchronized pin levels and the flags. The direction and data-out registers also drive the pad enable and pad value outputs directly.

Top module: `ep_intr_port`

## Requirements
- R1: After reset every writable register reads 0 (trigger field 0 selects level mode, direction 0 selects input, enables off, data-out 0), and `irq_o`, `pad_oe` and `pad_out` are all 0 while the pins idle high.
- R2: A pin change reaches the level-mode flag after two rising clock edges. It sets an edge-mode flag on the third rising edge and not before.
- R3: Trigger field value 01 (bits 2p+1:2p of the trigger register at offset 0 for pin p) latches the flag on a low-to-high transition only.
- R4: Trigger field value 10 latches the flag on a high-to-low transition only.
- R5: Trigger field value 11 latches the flag on either transition.
- R6: Trigger field value 00 makes the flag read 1 exactly while the synchronized pin is low. The flag does not latch, and a write of 1 to it has no effect.
- R7: Writing the flag register (offset 5) clears each edge-mode flag whose written bit is 1 and leaves the bits written with 0 unchanged.
- R8: When an edge event and a write-1 clear hit the same flag in the same cycle, the flag stays set.
- R9: A pin whose direction bit (offset 1) is 1 raises no edge flag.
- R10: `irq_o[p]` is 1 exactly when flag p is set and enable bit p (offset 2) is set.
- R11: Position 0 never sets its flag and never drives `irq_o[0]`, whatever its mode or level.
- R12: The registers read back as written: trigger at offset 0 (16 bits), direction at offset 1, enable at offset 2 and data-out at offset 3. Offset 4 reads the synchronized pin levels. `pad_oe` equals the direction register and `pad_out` equals the data-out register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NPINS | Asynchronous external pin levels |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pad_out | output | NPINS | Data-out register value |
| pad_oe | output | NPINS | Pad output enable (direction register) |
| irq_o | output | NPINS | Per-pin interrupt request |

## Verification
Several properties are checked on every cycle by the assertions. Position 0 never requests, and a request never appears without its enable bit. An edge flag never rises on a pin that was configured as an output. A latched flag falls only when a write-1 clear or a level-mode selection occurred in the previous cycle, and a detected event is always visible in the flag the next cycle, even when a clear coincided with it. The bench scenarios are needed to show the behaviour that depends on the stimulus. This covers the exact latency through the synchronizer and edge detector, the choice of polarity in each trigger mode, the non-latching level mirror, the register read-back and the effect of writing 0 to the flag register.

// File: rtl/ep_pkg.sv
// Shared definitions for the edge port interrupt unit: trigger encodings
// and the register offsets used by the bus decoder.
package ep_pkg;

    // Trigger field encoding, two bits per pin
    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'b00,
        TRIG_RISE  = 2'b01,
        TRIG_FALL  = 2'b10,
        TRIG_BOTH  = 2'b11
    } trig_e;

    // Register offsets on the configuration bus
    localparam logic [2:0] OFF_TRIG = 3'd0;
    localparam logic [2:0] OFF_DIR  = 3'd1;
    localparam logic [2:0] OFF_EN   = 3'd2;
    localparam logic [2:0] OFF_DOUT = 3'd3;
    localparam logic [2:0] OFF_PIN  = 3'd4;
    localparam logic [2:0] OFF_FLAG = 3'd5;

endpackage

// File: rtl/ep_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pin inputs.
// Assumes each bit is independent; reset loads RST_VAL so that idle-high
// pins do not produce a false edge or level after reset.
module ep_sync #(
    parameter int            W       = 8,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    // First stage samples the raw asynchronous input
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
    end

    // Remaining stages shift the sampled value along the chain
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/ep_regs.sv
// Register bank for the edge port: trigger modes, direction, enable and
// data-out storage, a write-1-to-clear strobe for the flags, and the
// combinational read mux. Assumes single-cycle write strobes.
module ep_regs
    import ep_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 3,
    localparam int TW    = 2 * NPINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_s,
    input  logic [NPINS-1:0]  flag_view,
    output logic [TW-1:0]     trig_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  en_q,
    output logic [NPINS-1:0]  dout_q,
    output logic [NPINS-1:0]  flag_clr
);

    logic [2:0] off;
    assign off = 3'(bus_addr);

    // Configuration register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= '0;
            dir_q  <= '0;
            en_q   <= '0;
            dout_q <= '0;
        end else if (bus_wr) begin
            case (off)
                OFF_TRIG: trig_q <= bus_wdata[TW-1:0];
                OFF_DIR:  dir_q  <= bus_wdata[NPINS-1:0];
                OFF_EN:   en_q   <= bus_wdata[NPINS-1:0];
                OFF_DOUT: dout_q <= bus_wdata[NPINS-1:0];
                default: ;
            endcase
        end
    end

    // Clear strobe for the flags: written ones only
    always_comb begin
        flag_clr = '0;
        if (bus_wr && off == OFF_FLAG) flag_clr = bus_wdata[NPINS-1:0];
    end

    // Read mux, zero-extended to the bus width
    always_comb begin
        bus_rdata = '0;
        case (off)
            OFF_TRIG: bus_rdata[TW-1:0]    = trig_q;
            OFF_DIR:  bus_rdata[NPINS-1:0] = dir_q;
            OFF_EN:   bus_rdata[NPINS-1:0] = en_q;
            OFF_DOUT: bus_rdata[NPINS-1:0] = dout_q;
            OFF_PIN:  bus_rdata[NPINS-1:0] = pin_s;
            OFF_FLAG: bus_rdata[NPINS-1:0] = flag_view;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ep_detect.sv
// Per-pin trigger logic: edge detection against the previous synchronized
// value, latched edge flags with write-1 clear (a new event wins), and a
// non-latching low-level mirror. Assumes pin_s is already synchronized.
// Position 0 is reserved and never produces an event or level.
module ep_detect
    import ep_pkg::*;
#(
    parameter int NPINS = 8,
    localparam int TW   = 2 * NPINS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_s,
    input  logic [TW-1:0]    trig_q,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] flag_clr,
    output logic [NPINS-1:0] edge_ev,
    output logic [NPINS-1:0] edge_flag,
    output logic [NPINS-1:0] flag_view
);

    logic [NPINS-1:0] prev_q;

    // Previous synchronized level, reset high to match idle pins
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= pin_s;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        localparam logic IS_SRC = (i != 0);
        trig_e mode;
        logic  rise, fall, active;

        assign mode   = trig_e'(trig_q[2*i +: 2]);
        assign rise   = pin_s[i] & ~prev_q[i];
        assign fall   = ~pin_s[i] & prev_q[i];
        assign active = IS_SRC & ~dir_q[i];

        // Event selection according to the trigger mode
        always_comb begin
            case (mode)
                TRIG_RISE: edge_ev[i] = active & rise;
                TRIG_FALL: edge_ev[i] = active & fall;
                TRIG_BOTH: edge_ev[i] = active & (rise | fall);
                default:   edge_ev[i] = 1'b0;
            endcase
        end

        // Latched edge flag: clear by write-1, a same-cycle event wins
        always_ff @(posedge clk) begin
            if (!rst_n)                  edge_flag[i] <= 1'b0;
            else if (mode == TRIG_LEVEL) edge_flag[i] <= 1'b0;
            else edge_flag[i] <= (edge_flag[i] & ~flag_clr[i]) | edge_ev[i];
        end

        // Visible flag: level mirror in level mode, latch otherwise
        assign flag_view[i] = (mode == TRIG_LEVEL) ? (active & ~pin_s[i])
                                                   : edge_flag[i];
    end

endmodule

// File: rtl/ep_intr_port.sv
// Edge port interrupt unit top. Synchronizes the pins, detects the
// configured trigger per pin and drives one request per pin, gated by
// its enable bit. Assumes a single clock domain for the bus.
module ep_intr_port
    import ep_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  irq_o
);

    localparam int TW = 2 * NPINS;

    logic [NPINS-1:0] pin_s;
    logic [TW-1:0]    trig_q;
    logic [NPINS-1:0] dir_q, en_q, dout_q, flag_clr;
    logic [NPINS-1:0] edge_ev, edge_flag, flag_view;

    ep_sync #(.W(NPINS), .STAGES(2), .RST_VAL('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_i),
        .q     (pin_s)
    );

    ep_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_s     (pin_s),
        .flag_view (flag_view),
        .trig_q    (trig_q),
        .dir_q     (dir_q),
        .en_q      (en_q),
        .dout_q    (dout_q),
        .flag_clr  (flag_clr)
    );

    ep_detect #(.NPINS(NPINS)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_s     (pin_s),
        .trig_q    (trig_q),
        .dir_q     (dir_q),
        .flag_clr  (flag_clr),
        .edge_ev   (edge_ev),
        .edge_flag (edge_flag),
        .flag_view (flag_view)
    );

    // Pad controls come straight from the registers; requests are gated
    assign pad_out = dout_q;
    assign pad_oe  = dir_q;
    assign irq_o   = flag_view & en_q;

endmodule

// File: rtl/ep_intr_port_chk.sv
// Assertion checker for the edge port interrupt unit, bound to the top.
// Observes ports plus the register and detector outputs.
module ep_intr_port_chk #(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 3,
    localparam int TW    = 2 * NPINS
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [15:0]       bus_wdata,
    input logic [NPINS-1:0]  irq_o,
    input logic [NPINS-1:0]  en_q,
    input logic [NPINS-1:0]  dir_q,
    input logic [TW-1:0]     trig_q,
    input logic [NPINS-1:0]  edge_ev,
    input logic [NPINS-1:0]  edge_flag
);

    function automatic logic [NPINS-1:0] level_mask(input logic [TW-1:0] t);
        logic [NPINS-1:0] m;
        for (int k = 0; k < NPINS; k++) m[k] = (t[2*k +: 2] == 2'b00);
        return m;
    endfunction

    logic [NPINS-1:0] clr_seen;
    assign clr_seen = (bus_wr && 3'(bus_addr) == 3'd5) ? bus_wdata[NPINS-1:0] : '0;

    // R11
    pos0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o[0] && !edge_flag[0]);

    // R10
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~en_q) == '0);

    // R9
    out_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_flag & ~$past(edge_flag) & $past(dir_q)) == '0);

    // R7
    flag_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(edge_flag) & ~edge_flag & ~$past(clr_seen) & ~level_mask($past(trig_q))) == '0);

    // R8
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(edge_ev) & ~edge_flag) == '0);

endmodule

bind ep_intr_port ep_intr_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .en_q      (en_q),
    .dir_q     (dir_q),
    .trig_q    (trig_q),
    .edge_ev   (edge_ev),
    .edge_flag (edge_flag)
);

// File: tb/tb_ep_intr_port.sv
`timescale 1ns/1ps
module tb_ep_intr_port;

    localparam int NPINS = 8;
    localparam logic [2:0] A_TRIG = 3'd0, A_DIR = 3'd1, A_EN = 3'd2,
                           A_DOUT = 3'd3, A_PIN = 3'd4, A_FLAG = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_i = 8'hFF;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  pad_out, pad_oe, irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ep_intr_port #(.NPINS(NPINS), .ADDR_W(3)) dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the following negedge
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic idle();
        pin_i = 8'hFF;
        cyc(4);
        wr(A_TRIG, 16'h0000);
        wr(A_DIR, 16'h0000);
        wr(A_EN, 16'h0000);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(A_TRIG, d); check("R1 trig", d, 16'h0);
        rd(A_DIR, d);  check("R1 dir", d, 16'h0);
        rd(A_EN, d);   check("R1 en", d, 16'h0);
        rd(A_DOUT, d); check("R1 dout", d, 16'h0);
        rd(A_FLAG, d); check("R1 flag", d, 16'h0);
        check("R1 irq", {8'h0, irq_o}, 16'h0);
        check("R1 pads", {pad_oe, pad_out}, 16'h0);
    endtask

    task automatic t_regs();
        logic [15:0] d;
        wr(A_TRIG, 16'hBEEF); rd(A_TRIG, d); check("R12 trig", d, 16'hBEEF);
        wr(A_DIR, 16'h005A);  rd(A_DIR, d);  check("R12 dir", d, 16'h005A);
        check("R12 pad_oe", {8'h0, pad_oe}, 16'h005A);
        wr(A_DOUT, 16'h003C); rd(A_DOUT, d); check("R12 dout", d, 16'h003C);
        check("R12 pad_out", {8'h0, pad_out}, 16'h003C);
        wr(A_EN, 16'h00C3);   rd(A_EN, d);   check("R12 en", d, 16'h00C3);
        pin_i = 8'hA5; cyc(2);
        rd(A_PIN, d); check("R12 pin levels", d, 16'h00A5);
        wr(A_DOUT, 16'h0000);
        idle();
    endtask

    task automatic t_level();
        logic [15:0] d;
        wr(A_EN, 16'h00FE);
        pin_i[3] = 1'b0;
        cyc(1); rd(A_FLAG, d); check("R2 level after 1 edge", d, 16'h0);
        cyc(1); rd(A_FLAG, d); check("R2 R6 level after 2 edges", d, 16'h0008);
        check("R10 level irq", {8'h0, irq_o}, 16'h0008);
        wr(A_FLAG, 16'h0008); rd(A_FLAG, d); check("R6 w1 no effect", d, 16'h0008);
        pin_i[3] = 1'b1; cyc(2);
        rd(A_FLAG, d); check("R6 not latched", d, 16'h0);
        check("R6 irq drops", {8'h0, irq_o}, 16'h0);
        idle();
    endtask

    task automatic t_rise();
        logic [15:0] d;
        wr(A_TRIG, 16'h0010); wr(A_EN, 16'h0004);
        pin_i[2] = 1'b0; cyc(4);
        rd(A_FLAG, d); check("R3 fall ignored", d, 16'h0);
        pin_i[2] = 1'b1;
        cyc(2); rd(A_FLAG, d); check("R2 edge not before 3rd", d, 16'h0);
        cyc(1); rd(A_FLAG, d); check("R2 R3 rise latched", d, 16'h0004);
        check("R10 rise irq", {8'h0, irq_o}, 16'h0004);
        wr(A_FLAG, 16'h00FB); rd(A_FLAG, d); check("R7 zero keeps", d, 16'h0004);
        wr(A_FLAG, 16'h0004); rd(A_FLAG, d); check("R7 one clears", d, 16'h0);
        idle();
    endtask

    task automatic t_fall();
        logic [15:0] d;
        wr(A_TRIG, 16'h0800);
        pin_i[5] = 1'b0; cyc(3);
        rd(A_FLAG, d); check("R4 fall latched", d, 16'h0020);
        wr(A_FLAG, 16'h0020);
        pin_i[5] = 1'b1; cyc(4);
        rd(A_FLAG, d); check("R4 rise ignored", d, 16'h0);
        idle();
    endtask

    task automatic t_both();
        logic [15:0] d;
        wr(A_TRIG, 16'h3000);
        pin_i[6] = 1'b0; cyc(3);
        rd(A_FLAG, d); check("R5 fall latched", d, 16'h0040);
        wr(A_FLAG, 16'h0040); rd(A_FLAG, d); check("R7 cleared", d, 16'h0);
        pin_i[6] = 1'b1; cyc(3);
        rd(A_FLAG, d); check("R5 rise latched", d, 16'h0040);
        idle();
    endtask

    task automatic t_enable();
        logic [15:0] d;
        wr(A_TRIG, 16'h0100);
        pin_i[4] = 1'b0; cyc(3); pin_i[4] = 1'b1; cyc(3);
        rd(A_FLAG, d); check("R10 flag set", d, 16'h0010);
        check("R10 irq off when disabled", {8'h0, irq_o}, 16'h0);
        wr(A_EN, 16'h0010);
        check("R10 irq on when enabled", {8'h0, irq_o}, 16'h0010);
        idle();
    endtask

    task automatic t_dir();
        logic [15:0] d;
        wr(A_TRIG, 16'hC000); wr(A_DIR, 16'h0080); wr(A_EN, 16'h0080);
        pin_i[7] = 1'b0; cyc(3); pin_i[7] = 1'b1; cyc(3);
        rd(A_FLAG, d); check("R9 output pin no flag", d, 16'h0);
        check("R9 output pin no irq", {8'h0, irq_o}, 16'h0);
        idle();
    endtask

    task automatic t_race();
        logic [15:0] d;
        wr(A_TRIG, 16'h000C);
        pin_i[1] = 1'b0; cyc(3);
        rd(A_FLAG, d); check("R8 setup flag", d, 16'h0002);
        pin_i[1] = 1'b1; cyc(2);
        wr(A_FLAG, 16'h0002);
        rd(A_FLAG, d); check("R8 event wins over clear", d, 16'h0002);
        wr(A_FLAG, 16'h0002);
        rd(A_FLAG, d); check("R8 later clear works", d, 16'h0);
        idle();
    endtask

    task automatic t_pin0();
        logic [15:0] d;
        wr(A_EN, 16'h00FF);
        pin_i[0] = 1'b0; cyc(3);
        rd(A_FLAG, d); check("R11 level pos0", d, 16'h0);
        wr(A_TRIG, 16'h0003);
        pin_i[0] = 1'b1; cyc(3); pin_i[0] = 1'b0; cyc(3);
        rd(A_FLAG, d); check("R11 edge pos0", d, 16'h0);
        check("R11 irq pos0", {8'h0, irq_o}, 16'h0);
        idle();
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_regs();
        t_level();
        t_rise();
        t_fall();
        t_both();
        t_enable();
        t_dir();
        t_race();
        t_pin0();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule